// File: doc/BRIEF.md
# Dual-Channel Component Video Stream Splitter

This block receives two independent byte-serial 4:2:2 component video streams (BT.656 style) on one capture port, one sample lane per channel. Each lane carries a repeating Cb, Y, Cr, Y sample sequence. The Cb and Cr of each group describe the pixel of the first Y in that group. The second Y is the luma of the following pixel. Timing reference codes are embedded in the stream. The block locks onto them and forwards only active-video samples. Each component is steered into its own FIFO, so a downstream data mover can drain the luma plane and the two chroma planes of each channel separately.

For each channel the block also reports the current field, vertical blanking and whether a line is open, and gives a one-cycle pulse when an active line ends. Every FIFO has a sticky overflow flag. A FIFO that is full drops the incoming sample and sets its flag, and software clears the flag by writing a 1 to the matching clear bit.

Top module: `bt656_demux`

## Requirements
- R1: After a start-of-line code, accepted samples go to the FIFOs in the repeating order Cb, Y, Cr, Y. Per channel c, FIFO index c*3+0 holds Y, c*3+1 holds Cb and c*3+2 holds Cr. Each chroma FIFO therefore receives one sample for every two luma samples.
- R2: The component phase restarts at Cb on every valid start-of-line code, even when the previous line ended mid-group.
- R3: Samples are written only between a valid start-of-line code and the next valid end-of-line code, and only when that start code had its blanking bit clear. Samples in horizontal or vertical blanking are discarded.
- R4: A timing code is the sample sequence all-ones, zero, zero, then a status word. The status word is taken from the top 8 bits of the W-bit sample and is laid out as follows:
  - bit7 = 1;
  - bit6 = field F;
  - bit5 = vertical blanking V;
  - bit4 = H, where 0 means start of line and 1 means end of line;
  - bit3 = V^H, bit2 = F^H, bit1 = F^V and bit0 = F^V^H.
  None of the four code samples is written to a FIFO.
- R5: A status word whose protection bits or bit7 are inconsistent is ignored. Field, blanking, line state and phase all keep their previous values.
- R6: `field_id` and `vblank` follow the F and V bits of the last valid status word and change one cycle after it is accepted. Reset values are field 0 and vblank 1.
- R7: `line_end` pulses high for exactly one cycle, one cycle after a valid end-of-line code that closes an open active line. No pulse occurs when no line was open.
- R8: Each FIFO returns samples in arrival order. Read data is registered and appears one cycle after `rd_en` while the FIFO is not empty. A read of an empty FIFO leaves the data unchanged. All FIFOs are empty after reset.
- R9: A sample written to a full FIFO is dropped, the stored contents stay intact, and that FIFO's overflow flag is set and stays set.
- R10: Writing 1 to a bit of `ovf_clr` clears the matching flag. If a drop and a clear fall in the same cycle, the flag stays set.
- R11: The two channels are independent. Traffic on one lane never changes the other channel's FIFOs or status.
- R12: The sample width W is a parameter, 8 or 10 bits. The code values and the stored samples use the full width W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | NCH | Per-lane sample strobe |
| in_data | input | NCH*W | Per-lane sample, lane c at [c*W +: W] |
| rd_en | input | NCH*3 | Per-FIFO read request |
| rd_data | output | NCH*3*W | Per-FIFO registered read data |
| fifo_empty | output | NCH*3 | Per-FIFO empty flag |
| ovf_flag | output | NCH*3 | Per-FIFO sticky overflow flag |
| ovf_clr | input | NCH*3 | Write-1-to-clear for the overflow flags |
| field_id | output | NCH | Current field per channel |
| vblank | output | NCH | Vertical blanking per channel |
| line_active | output | NCH | Active line open per channel |
| line_end | output | NCH | One-cycle end-of-active-line pulse |

## Verification
Dropping a sample into a full FIFO and clearing that FIFO's overflow flag can happen in the same cycle. The bench fills the luma FIFO past its depth and then opens a new line. It drives a luma sample together with the clear bit for that FIFO, and expects the flag to remain set. A later clear on its own must drop the flag. The bench also drives both lanes on the same cycles with different field bits, and checks that each channel keeps its own status and its own FIFO contents.

// File: rtl/bt656_demux_pkg.sv
package bt656_demux_pkg;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;

  localparam int PL_Y    = 0;
  localparam int PL_CB   = 1;
  localparam int PL_CR   = 2;
  localparam int NPLANE  = 3;

  // Status word: 1 F V H P3 P2 P1 P0
  function automatic logic status_ok(input logic [7:0] s);
    return s[7]
        && (s[3] == (s[5] ^ s[4]))
        && (s[2] == (s[6] ^ s[4]))
        && (s[1] == (s[6] ^ s[5]))
        && (s[0] == (s[6] ^ s[5] ^ s[4]));
  endfunction

endpackage

// File: rtl/bt656_trc_parser.sv
module bt656_trc_parser
  import bt656_demux_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic [W-1:0] din,
  output logic         smp_wr,
  output logic [1:0]   smp_plane,
  output logic         field_o,
  output logic         vblank_o,
  output logic         active_o,
  output logic         line_end_o
);

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ALL_ZERO = '0;

  // preamble progress: 0 none, 1 ones seen, 2 one zero, 3 two zeros
  logic [1:0]  pre_q;
  phase_e      ph_q;
  logic [7:0]  stat;
  logic        is_ones, is_zero, code_byte, at_status, status_good;

  assign stat        = din[W-1 -: 8];
  assign is_ones     = (din == ALL_ONES);
  assign is_zero     = (din == ALL_ZERO);
  assign at_status   = (pre_q == 2'd3);
  assign status_good = status_ok(stat);
  assign code_byte   = is_ones || at_status
                    || (is_zero && (pre_q == 2'd1 || pre_q == 2'd2));

  assign smp_wr = vld && active_o && !code_byte;

  always_comb begin
    case (ph_q)
      PH_CB:   smp_plane = 2'(PL_CB);
      PH_CR:   smp_plane = 2'(PL_CR);
      default: smp_plane = 2'(PL_Y);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q      <= 2'd0;
      ph_q       <= PH_CB;
      field_o    <= 1'b0;
      vblank_o   <= 1'b1;
      active_o   <= 1'b0;
      line_end_o <= 1'b0;
    end else begin
      line_end_o <= 1'b0;
      if (vld) begin
        if (is_ones)                        pre_q <= 2'd1;
        else if (is_zero && pre_q == 2'd1)  pre_q <= 2'd2;
        else if (is_zero && pre_q == 2'd2)  pre_q <= 2'd3;
        else                                pre_q <= 2'd0;

        if (at_status && status_good) begin
          field_o  <= stat[6];
          vblank_o <= stat[5];
          if (!stat[4]) begin
            active_o <= !stat[5];
            ph_q     <= PH_CB;
          end else begin
            active_o   <= 1'b0;
            line_end_o <= active_o;
          end
        end else if (smp_wr) begin
          ph_q <= phase_e'(ph_q + 2'd1);
        end
      end
    end
  end

endmodule

// File: rtl/bt656_plane_fifo.sv
module bt656_plane_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         drop
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          wr_ok, rd_ok;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_FULL);
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;
  assign drop  = wr && full;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_ok) begin
      rdata <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/bt656_demux.sv
module bt656_demux
  import bt656_demux_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int W     = 10,
  parameter int DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          in_vld,
  input  logic [NCH*W-1:0]        in_data,
  input  logic [NCH*NPLANE-1:0]   rd_en,
  output logic [NCH*NPLANE*W-1:0] rd_data,
  output logic [NCH*NPLANE-1:0]   fifo_empty,
  output logic [NCH*NPLANE-1:0]   ovf_flag,
  input  logic [NCH*NPLANE-1:0]   ovf_clr,
  output logic [NCH-1:0]          field_id,
  output logic [NCH-1:0]          vblank,
  output logic [NCH-1:0]          line_active,
  output logic [NCH-1:0]          line_end
);

  localparam int NF = NCH * NPLANE;

  logic [NCH-1:0] smp_wr;
  logic [1:0]     smp_plane [NCH];
  logic [NF-1:0]  fifo_wr;
  logic [NF-1:0]  fifo_full;
  logic [NF-1:0]  drop;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bt656_trc_parser #(.W(W)) u_parse (
      .clk        (clk),
      .rst        (rst),
      .vld        (in_vld[c]),
      .din        (in_data[c*W +: W]),
      .smp_wr     (smp_wr[c]),
      .smp_plane  (smp_plane[c]),
      .field_o    (field_id[c]),
      .vblank_o   (vblank[c]),
      .active_o   (line_active[c]),
      .line_end_o (line_end[c])
    );

    for (genvar p = 0; p < NPLANE; p++) begin : g_pl
      localparam int IDX = c*NPLANE + p;

      assign fifo_wr[IDX] = smp_wr[c] && (smp_plane[c] == 2'(p));

      bt656_plane_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (fifo_wr[IDX]),
        .wdata (in_data[c*W +: W]),
        .rd    (rd_en[IDX]),
        .rdata (rd_data[IDX*W +: W]),
        .empty (fifo_empty[IDX]),
        .full  (fifo_full[IDX]),
        .drop  (drop[IDX])
      );

      always_ff @(posedge clk) begin
        if (rst)                ovf_flag[IDX] <= 1'b0;
        else if (drop[IDX])     ovf_flag[IDX] <= 1'b1;
        else if (ovf_clr[IDX])  ovf_flag[IDX] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bt656_demux_chk.sv
module bt656_demux_chk #(
  parameter int NCH = 2,
  parameter int W   = 10
) (
  input logic                clk,
  input logic                rst,
  input logic [NCH*3-1:0]    rd_en,
  input logic [NCH*3*W-1:0]  rd_data,
  input logic [NCH*3-1:0]    fifo_empty,
  input logic [NCH*3-1:0]    ovf_flag,
  input logic [NCH*3-1:0]    ovf_clr,
  input logic [NCH-1:0]      line_active,
  input logic [NCH-1:0]      line_end,
  input logic [NCH*3-1:0]    fifo_wr,
  input logic [NCH*3-1:0]    drop
);

  for (genvar i = 0; i < NCH*3; i++) begin : g_f
    p_reset_empty_r8: assert property (@(posedge clk)
      rst |=> fifo_empty[i]);
    p_rd_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (rd_en[i] && fifo_empty[i]) |=> $stable(rd_data[i*W +: W]));
    p_ovf_set_r9: assert property (@(posedge clk) disable iff (rst)
      drop[i] |=> ovf_flag[i]);
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag[i] && !ovf_clr[i]) |=> ovf_flag[i]);
    p_ovf_clear_r10: assert property (@(posedge clk) disable iff (rst)
      (ovf_clr[i] && !drop[i]) |=> !ovf_flag[i]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_write_in_line_r3: assert property (@(posedge clk) disable iff (rst)
      (|fifo_wr[c*3 +: 3]) |-> line_active[c]);
    p_one_plane_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(fifo_wr[c*3 +: 3]));
    p_line_end_single_r7: assert property (@(posedge clk) disable iff (rst)
      line_end[c] |=> (!line_end[c] && !line_active[c]));
  end

endmodule

bind bt656_demux bt656_demux_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .fifo_empty  (fifo_empty),
  .ovf_flag    (ovf_flag),
  .ovf_clr     (ovf_clr),
  .line_active (line_active),
  .line_end    (line_end),
  .fifo_wr     (fifo_wr),
  .drop        (drop)
);

// File: tb/bt656_demux_tb.sv
`timescale 1ns/1ps
module bt656_demux_tb;
  localparam int NCH = 2, W = 10, DEPTH = 16, NF = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic [NCH-1:0]    in_vld;
  logic [NCH*W-1:0]  in_data;
  logic [NF-1:0]     rd_en;
  logic [NF*W-1:0]   rd_data;
  logic [NF-1:0]     fifo_empty, ovf_flag, ovf_clr;
  logic [NCH-1:0]    field_id, vblank, line_active, line_end;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] q [NF][$];
  bit mdl_ovf [NF];

  always #2 clk = ~clk;

  bt656_demux #(.NCH(NCH), .W(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .field_id(field_id),
    .vblank(vblank), .line_active(line_active), .line_end(line_end)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // status word per R4, placed in the top 8 bits of W
  function automatic logic [W-1:0] status_word(input bit f, input bit v, input bit h);
    logic [7:0] s;
    s = {1'b1, f, v, h, v^h, f^h, f^v, f^v^h};
    return {s, {(W-8){1'b0}}};
  endfunction

  function automatic logic [W-1:0] rnd_sample();
    return W'(16 + ($urandom % 1000));
  endfunction

  // R1 mapping: phase 0 Cb, 1 Y, 2 Cr, 3 Y
  function automatic int pidx(input int ch, input int k);
    case (k % 4)
      0:       return ch*3 + 1;
      2:       return ch*3 + 2;
      default: return ch*3 + 0;
    endcase
  endfunction

  task automatic push(input int idx, input logic [W-1:0] d);
    if (q[idx].size() < DEPTH) q[idx].push_back(d);
    else mdl_ovf[idx] = 1'b1;
  endtask

  task automatic send(input int ch, input logic [W-1:0] d);
    @(negedge clk);
    in_vld = '0;
    in_vld[ch] = 1'b1;
    in_data[ch*W +: W] = d;
  endtask

  task automatic send2(input logic [W-1:0] d0, input logic [W-1:0] d1);
    @(negedge clk);
    in_vld = 2'b11;
    in_data = {d1, d0};
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = '0;
  endtask

  task automatic code(input int ch, input bit f, input bit v, input bit h, input bit bad);
    logic [W-1:0] sw;
    sw = status_word(f, v, h);
    if (bad) sw[W-8] = ~sw[W-8];
    send(ch, '1);
    send(ch, '0);
    send(ch, '0);
    send(ch, sw);
  endtask

  task automatic line(input int ch, input bit f, input bit v, input int n);
    logic [W-1:0] d;
    code(ch, f, v, 1'b0, 1'b0);
    idle();
    chk(field_id[ch] == f, "R6 field after start code", int'(field_id[ch]), int'(f));
    chk(vblank[ch] == v, "R6 vblank after start code", int'(vblank[ch]), int'(v));
    chk(line_active[ch] == !v, "R3 line open state", int'(line_active[ch]), int'(!v));
    for (int k = 0; k < n; k++) begin
      d = rnd_sample();
      send(ch, d);
      if (!v) push(pidx(ch, k), d);
    end
    code(ch, f, v, 1'b1, 1'b0);
    idle();
    chk(line_end[ch] == !v, "R7 end pulse", int'(line_end[ch]), int'(!v));
    idle();
    chk(line_end[ch] == 1'b0, "R7 pulse width", int'(line_end[ch]), 0);
  endtask

  task automatic rd_check(input int idx, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    rd_en[idx] = 1'b1;
    @(negedge clk);
    rd_en[idx] = 1'b0;
    chk(rd_data[idx*W +: W] == exp, req, int'(rd_data[idx*W +: W]), int'(exp));
  endtask

  task automatic drain(input int idx, input string req);
    while (q[idx].size() > 0) rd_check(idx, q[idx].pop_front(), req);
    @(negedge clk);
    chk(fifo_empty[idx] == 1'b1, {req, " empty after drain"}, int'(fifo_empty[idx]), 1);
  endtask

  task automatic drain_all(input string req);
    for (int i = 0; i < NF; i++) drain(i, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    logic [W-1:0] d0, d1, hold;
    void'($urandom(32'd2024));
    rst = 1'b1; in_vld = '0; in_data = '0; rd_en = '0; ovf_clr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state, R8 R6
    chk(fifo_empty == '1, "R8 reset empty", int'(fifo_empty), 63);
    chk(ovf_flag == '0, "R9 reset flags", int'(ovf_flag), 0);
    chk(field_id == '0 && vblank == '1, "R6 reset status", int'({field_id, vblank}), 3);
    chk(line_active == '0 && line_end == '0, "R7 reset line", int'({line_active, line_end}), 0);

    // R1 R8 basic line, R12 full-width samples
    line(0, 1'b0, 1'b0, 8);
    drain_all("R1 order");

    // R2 odd-length line then new line restarts at Cb
    line(0, 1'b0, 1'b0, 7);
    line(0, 1'b0, 1'b0, 4);
    drain_all("R2 phase restart");

    // R3 vertical blanking line writes nothing; horizontal blanking discarded
    line(0, 1'b1, 1'b1, 6);
    for (int k = 0; k < 5; k++) send(0, rnd_sample());
    idle();
    chk(fifo_empty[2:0] == 3'b111, "R3 blanking discarded", int'(fifo_empty[2:0]), 7);

    // R7 end code without open line: no pulse
    code(0, 1'b1, 1'b0, 1'b1, 1'b0);
    idle();
    chk(line_end[0] == 1'b0, "R7 no pulse without line", int'(line_end[0]), 0);

    // R5 corrupted end code ignored, corrupted start code ignored
    code(0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin d0 = rnd_sample(); send(0, d0); push(pidx(0, k), d0); end
    code(0, 1'b0, 1'b0, 1'b1, 1'b1);
    idle();
    chk(line_active[0] == 1'b1, "R5 bad end code ignored", int'(line_active[0]), 1);
    chk(line_end[0] == 1'b0, "R5 no pulse on bad code", int'(line_end[0]), 0);
    for (int k = 4; k < 8; k++) begin d0 = rnd_sample(); send(0, d0); push(pidx(0, k), d0); end
    code(0, 1'b0, 1'b0, 1'b1, 1'b0);
    code(0, 1'b1, 1'b0, 1'b0, 1'b1);
    idle();
    chk(field_id[0] == 1'b0, "R5 bad start keeps field", int'(field_id[0]), 0);
    chk(line_active[0] == 1'b0, "R5 bad start keeps closed", int'(line_active[0]), 0);
    send(0, rnd_sample());
    idle();
    drain_all("R5 data around bad codes");

    // R9 overflow on luma
    line(0, 1'b0, 1'b0, 40);
    chk(ovf_flag[0] == 1'b1, "R9 luma overflow set", int'(ovf_flag[0]), 1);
    chk(ovf_flag[2:1] == 2'b00, "R9 chroma no overflow", int'(ovf_flag[2:1]), 0);
    // R10 drop and clear in the same cycle: set wins
    code(0, 1'b0, 1'b0, 1'b0, 1'b0);
    d0 = rnd_sample(); send(0, d0); push(1, d0);
    @(negedge clk);
    hold = rnd_sample();
    in_vld = 2'b01; in_data[W-1:0] = hold; ovf_clr = 6'b000001;
    push(0, hold);
    @(negedge clk);
    in_vld = '0; ovf_clr = '0;
    chk(ovf_flag[0] == 1'b1, "R10 set wins over clear", int'(ovf_flag[0]), 1);
    @(negedge clk);
    chk(ovf_flag[0] == 1'b1, "R9 flag sticky", int'(ovf_flag[0]), 1);
    ovf_clr = 6'b000001;
    @(negedge clk);
    ovf_clr = '0;
    chk(ovf_flag[0] == 1'b0, "R10 clear by write one", int'(ovf_flag[0]), 0);
    code(0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle();
    drain_all("R9 contents intact");

    // R11 lane 1 alone leaves lane 0 untouched
    line(1, 1'b1, 1'b0, 6);
    chk(field_id[0] == 1'b0, "R11 lane0 field untouched", int'(field_id[0]), 0);
    chk(fifo_empty[2:0] == 3'b111, "R11 lane0 fifos untouched", int'(fifo_empty[2:0]), 7);
    drain_all("R11 lane1 data");

    // R11 both lanes on the same cycles, different fields
    send2('1, '1); send2('0, '0); send2('0, '0);
    send2(status_word(1'b1, 1'b0, 1'b0), status_word(1'b0, 1'b0, 1'b0));
    for (int k = 0; k < 12; k++) begin
      d0 = rnd_sample(); d1 = rnd_sample();
      send2(d0, d1);
      push(pidx(0, k), d0); push(pidx(1, k), d1);
    end
    send2('1, '1); send2('0, '0); send2('0, '0);
    send2(status_word(1'b1, 1'b0, 1'b1), status_word(1'b0, 1'b0, 1'b1));
    idle();
    chk(line_end == 2'b11, "R11 both end pulses", int'(line_end), 3);
    chk(field_id == 2'b01, "R11 independent fields", int'(field_id), 1);
    drain_all("R11 dual lane data");

    // random lines, R1 R3 R6
    for (int t = 0; t < 10; t++) begin
      int ch = $urandom % 2;
      line(ch, bit'($urandom % 2), bit'(($urandom % 4) == 0), 1 + ($urandom % 14));
      drain_all("R1 random line");
    end

    report();
  end
endmodule